// File: doc/BRIEF.md
# Per-Block Configuration Decompressor

This block sits at the configuration entry point of one logic block or cluster. The stream that crosses the device stays short: a serial bitstream of prefix-free variable-length codewords arrives one bit per cycle. Each codeword names one entry in a small table of the block's most frequently used configurations. The decoder then emits the selected full-width configuration word toward the block's configuration chain. One reserved symbol works as an escape. After the escape, the next `CFG_W` stream bits are taken as an uncoded configuration and emitted unchanged. This covers random logic that the table does not hold.

The codes follow a canonical scheme. For every code length from 1 to `MAX_LEN` the block holds three loadable registers: the first (lowest) code of that length, the number of codes of that length, and the rank of the first symbol of that length. A matched rank selects a table entry directly. Configuration software builds the code set offline and loads the table and the per-length registers through a write port. It may do so only while the decoder sits between symbols.

The input is a bit with valid/ready and a start-of-stream marker. The output is a word with valid/ready, and input is held off while a word waits to be taken. An undecodable codeword sets a sticky error. Bits are then dropped until a new stream starts.

Top module: `cfg_decomp`

## Requirements
- R1: After reset `out_valid`, `dec_err` and `wr_err` are 0 and `in_ready` is 1.
- R2: Bits are taken MSB first, and the first bit of a codeword enters at the least significant end as the code grows. A code `c` of length `L` matches when `first[L] <= c < first[L] + count[L]`. Its rank is `base[L] + (c - first[L])`. A rank below `DEPTH` makes the block emit `table[rank]` in the cycle after the last code bit is accepted.
- R3: Matching is tried at every length as bits arrive, and the shortest matching length wins. Codes of different lengths in one stream are each decoded separately.
- R4: The rank equal to `DEPTH` (16) is the escape. The next `CFG_W` accepted bits, first bit as the MSB, are emitted as one word unchanged, and decoding then resumes with a new codeword.
- R5: While `out_valid` is 1, `in_ready` is 0, and `out_cfg` stays stable until `out_ready` accepts the word.
- R6: A code that matches nothing by length `MAX_LEN`, or that matches with a rank above `DEPTH`, produces no word and sets `dec_err`. `dec_err` stays set until reset, and later bits are dropped until one arrives with `in_sof`.
- R7: A bit accepted with `in_sof` = 1 discards any partial codeword, escape payload or error state, and starts a new codeword with that bit.
- R8: Write select encoding: 0 = table entry `wr_addr`, 1 = first code, 2 = code count, 3 = base rank. For selects 1 to 3, `wr_addr` = length − 1. A write takes effect when the decoder is idle, meaning no partial code, no escape payload and no pending output word.
- R9: A write issued while the decoder is not idle leaves all registers unchanged and sets the sticky `wr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream bit valid |
| in_ready | output | 1 | Stream bit accepted when high with in_valid |
| in_bit | input | 1 | Stream bit |
| in_sof | input | 1 | Marks the first bit of a new stream |
| out_valid | output | 1 | Configuration word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_cfg | output | CFG_W | Decompressed configuration word |
| wr_en | input | 1 | Register / table write strobe |
| wr_sel | input | 2 | Write target select |
| wr_addr | input | A_W | Table index or length − 1 |
| wr_data | input | CFG_W | Write data (low bits used for code registers) |
| dec_err | output | 1 | Sticky undecodable-code flag |
| wr_err | output | 1 | Sticky write-while-busy flag |

## Verification
The bench decodes every rank across short and long codes. A design that compared against the wrong length, or that mishandled the canonical offset, would emit the wrong table entry. It checks the escape payload boundary, where an off-by-one would swallow a bit of the next codeword or emit early, and it checks a stream restart in the middle of an escape payload. It drives an all-ones codeword that matches no length, then checks that the following bits without a start marker produce nothing and that a marked bit recovers. It also writes a table entry in the middle of a codeword, which a design that ignores the busy rule would corrupt in the word that follows.

// File: rtl/cfg_decomp.sv
module cfg_decomp #(
  parameter int CFG_W   = 16,
  parameter int DEPTH   = 16,
  parameter int MAX_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_bit,
  input  logic                 in_sof,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CFG_W-1:0]     out_cfg,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [((($clog2(DEPTH)) > ($clog2(MAX_LEN))) ? $clog2(DEPTH) : $clog2(MAX_LEN))-1:0] wr_addr,
  input  logic [CFG_W-1:0]     wr_data,
  output logic                 dec_err,
  output logic                 wr_err
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int RK_W  = IDX_W + 1;
  localparam int LI_W  = $clog2(MAX_LEN);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int RC_W  = $clog2(CFG_W);

  typedef enum logic [1:0] {ST_CODE, ST_RAW, ST_ERR} st_t;

  st_t                st;
  logic [CFG_W-1:0]   tbl   [DEPTH];
  logic [MAX_LEN-1:0] fc    [MAX_LEN];
  logic [RK_W-1:0]    cnt   [MAX_LEN];
  logic [RK_W-1:0]    base  [MAX_LEN];
  logic [MAX_LEN-1:0] code;
  logic [LEN_W-1:0]   len;
  logic [CFG_W-1:0]   raw;
  logic [RC_W-1:0]    rcnt;

  st_t                eff;
  logic [MAX_LEN-1:0] code_n, off;
  logic [LEN_W-1:0]   len_n;
  logic [LI_W-1:0]    li;
  logic [RK_W-1:0]    rank;
  logic               hit, is_esc, bad, acc, idle;

  assign in_ready = !out_valid;
  assign acc      = in_valid && in_ready;
  assign idle     = (st != ST_RAW) && (len == '0) && !out_valid;
  assign eff      = in_sof ? ST_CODE : st;

  assign code_n = in_sof ? MAX_LEN'(in_bit) : {code[MAX_LEN-2:0], in_bit};
  assign len_n  = (in_sof ? '0 : len) + LEN_W'(1);
  assign li     = LI_W'(len_n - LEN_W'(1));
  assign off    = code_n - fc[li];
  assign hit    = (code_n >= fc[li]) && (off < MAX_LEN'(cnt[li]));
  assign rank   = base[li] + RK_W'(off);
  assign is_esc = hit && (rank == RK_W'(DEPTH));
  assign bad    = (hit && rank > RK_W'(DEPTH)) || (!hit && len_n == LEN_W'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_CODE;
      code      <= '0;
      len       <= '0;
      raw       <= '0;
      rcnt      <= '0;
      out_valid <= 1'b0;
      out_cfg   <= '0;
      dec_err   <= 1'b0;
      wr_err    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      for (int i = 0; i < MAX_LEN; i++) begin
        fc[i]   <= '0;
        cnt[i]  <= '0;
        base[i] <= '0;
      end
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;

      if (acc) begin
        case (eff)
          ST_CODE: begin
            code <= '0;
            len  <= '0;
            if (bad) begin
              st      <= ST_ERR;
              dec_err <= 1'b1;
            end else if (is_esc) begin
              st   <= ST_RAW;
              rcnt <= '0;
            end else if (hit) begin
              st        <= ST_CODE;
              out_valid <= 1'b1;
              out_cfg   <= tbl[rank[IDX_W-1:0]];
            end else begin
              st   <= ST_CODE;
              code <= code_n;
              len  <= len_n;
            end
          end
          ST_RAW: begin
            raw <= {raw[CFG_W-2:0], in_bit};
            if (rcnt == RC_W'(CFG_W - 1)) begin
              st        <= ST_CODE;
              out_valid <= 1'b1;
              out_cfg   <= {raw[CFG_W-2:0], in_bit};
            end else begin
              rcnt <= rcnt + RC_W'(1);
            end
          end
          default: ;
        endcase
      end

      if (wr_en) begin
        if (!idle) begin
          wr_err <= 1'b1;
        end else begin
          case (wr_sel)
            2'd0: tbl[wr_addr[IDX_W-1:0]] <= wr_data;
            2'd1: fc[wr_addr[LI_W-1:0]]   <= wr_data[MAX_LEN-1:0];
            2'd2: cnt[wr_addr[LI_W-1:0]]  <= wr_data[RK_W-1:0];
            default: base[wr_addr[LI_W-1:0]] <= wr_data[RK_W-1:0];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfg_decomp_chk.sv
module cfg_decomp_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CFG_W-1:0] out_cfg,
  input logic             dec_err,
  input logic             wr_err
);
  assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cfg));

  assert_stall_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_word_needs_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_dec_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> dec_err);

  assert_dec_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_err) |-> $past(in_valid && in_ready));

  assert_wr_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
endmodule

bind cfg_decomp cfg_decomp_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_cfg(out_cfg),
  .dec_err(dec_err), .wr_err(wr_err)
);

// File: tb/sim_cfg_decomp.sv
module sim_cfg_decomp;
  localparam int CFG_W = 16;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_bit = 0, in_sof = 0, in_ready;
  logic out_valid, out_ready = 1;
  logic [CFG_W-1:0] out_cfg;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [3:0] wr_addr = 0;
  logic [CFG_W-1:0] wr_data = 0;
  logic dec_err, wr_err;

  int checks = 0, fails = 0, cyc = 0, stall = 0;
  logic [CFG_W-1:0] tbl_m [16];
  logic [CFG_W-1:0] expq [$];

  always #5 clk = ~clk;

  cfg_decomp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
    .out_cfg(out_cfg), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .dec_err(dec_err), .wr_err(wr_err)
  );

  task automatic chk(input logic ok, input string tag, input logic [CFG_W-1:0] act, input logic [CFG_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (stall)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3 == 0);
      default: out_ready = 1'b0;
    endcase
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) chk(1'b0, "R2/R6 unexpected word", out_cfg, '0);
      else begin
        logic [CFG_W-1:0] e;
        e = expq.pop_front();
        chk(out_cfg == e, "R2/R4 word", out_cfg, e);
      end
    end
  end

  task automatic put_bit(input logic b, input logic s);
    @(negedge clk);
    in_valid = 1; in_bit = b; in_sof = s;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 0; in_sof = 0;
  endtask

  task automatic send_bits(input logic [CFG_W-1:0] v, input int n, input logic sof);
    for (int i = n - 1; i >= 0; i--) put_bit(v[i], sof && (i == n - 1));
  endtask

  task automatic code_for(input int r, output logic [7:0] c, output int l);
    if (r == 0) begin c = 8'b00; l = 2; end
    else if (r <= 2) begin c = 8'(2 + r - 1); l = 3; end
    else if (r == 3) begin c = 8'd8; l = 4; end
    else if (r == 16) begin c = 8'd18; l = 5; end
    else begin c = 8'(38 + r - 4); l = 6; end
  endtask

  task automatic sym(input int r, input logic sof);
    logic [7:0] c; int l;
    code_for(r, c, l);
    expq.push_back(tbl_m[r]);
    send_bits(CFG_W'(c), l, sof);
  endtask

  task automatic esc_raw(input logic [CFG_W-1:0] d);
    expq.push_back(d);
    send_bits(CFG_W'(5'b10010), 5, 1'b0);
    send_bits(d, CFG_W, 1'b0);
  endtask

  task automatic wr(input logic [1:0] s, input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_addr = 4'(a); wr_data = CFG_W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int fcv [8] = '{0, 0, 2, 8, 18, 38, 100, 200};
    int cnv [8] = '{0, 1, 2, 1, 1, 12, 0, 0};
    int bsv [8] = '{0, 0, 1, 3, 16, 4, 16, 16};
    for (int i = 0; i < 16; i++) tbl_m[i] = CFG_W'(i * 16'h0F1 + 16'h3A05);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid", CFG_W'(out_valid), 0);
    chk(!dec_err, "R1 dec_err", CFG_W'(dec_err), 0);
    chk(!wr_err, "R1 wr_err", CFG_W'(wr_err), 0);
    chk(in_ready, "R1 in_ready", CFG_W'(in_ready), 1);

    // R8: load while idle
    for (int i = 0; i < 16; i++) wr(2'd0, i, int'(tbl_m[i]));
    for (int l = 0; l < 8; l++) begin
      wr(2'd1, l, fcv[l]);
      wr(2'd2, l, cnv[l]);
      wr(2'd3, l, bsv[l]);
    end
    chk(!wr_err, "R8 idle writes accepted", CFG_W'(wr_err), 0);

    // R2 R3: every rank, mixed lengths back to back
    for (int r = 0; r < 16; r++) sym(r, r == 0);
    sym(0, 0); sym(15, 0); sym(3, 0); sym(1, 0);
    go_idle(); drain();

    // R4: escape payload then normal codes
    esc_raw(16'hBEEF); sym(0, 0); esc_raw(16'h0001); sym(2, 0);
    go_idle(); drain();

    // R5: backpressure
    stall = 2;
    sym(5, 0); go_idle();
    repeat (3) @(negedge clk);
    chk(out_valid, "R5 word held", CFG_W'(out_valid), 1);
    chk(!in_ready, "R5 input stalled", CFG_W'(in_ready), 0);
    chk(out_cfg == tbl_m[5], "R5 word stable", out_cfg, tbl_m[5]);
    stall = 1;
    sym(7, 0); sym(0, 0); esc_raw(16'h5A5A); sym(9, 0);
    go_idle(); drain();
    stall = 0;

    // R7: restart mid-code and mid-escape
    put_bit(1'b1, 1'b0);
    sym(0, 1);
    send_bits(CFG_W'(5'b10010), 5, 1'b0);
    send_bits(CFG_W'(5'b10110), 5, 1'b0);
    sym(2, 1);
    go_idle(); drain();

    // R9: write in the middle of a codeword is dropped
    put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0); go_idle();
    wr(2'd0, 3, 16'hDEAD);
    chk(wr_err, "R9 wr_err set", CFG_W'(wr_err), 1);
    expq.push_back(tbl_m[3]);
    send_bits(CFG_W'(2'b00), 2, 1'b0);
    go_idle(); drain();
    tbl_m[3] = 16'hC0DE;
    wr(2'd0, 3, 16'hC0DE);
    sym(3, 0); go_idle(); drain();
    chk(wr_err, "R9 wr_err sticky", CFG_W'(wr_err), 1);

    // R6: unmatched code, then bits dropped, then R7 recovery
    send_bits(CFG_W'(8'hFF), 8, 1'b0);
    go_idle();
    chk(dec_err, "R6 dec_err set", CFG_W'(dec_err), 1);
    send_bits(CFG_W'(2'b00), 2, 1'b0);
    go_idle(); repeat (4) @(negedge clk);
    chk(!out_valid, "R6 bits dropped", CFG_W'(out_valid), 0);
    sym(1, 1); sym(12, 0);
    go_idle(); drain();
    chk(dec_err, "R6 dec_err sticky", CFG_W'(dec_err), 1);

    chk(expq.size() == 0, "R2 all words seen", CFG_W'(expq.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule